// File: doc/BRIEF.md
# Bidirectional repetitive padding line unit

This block fills the holes in one scan line of pixels for object-based video coding. Each pixel arrives with a shape bit telling whether it belongs to the object. Pixels inside the object pass through unchanged. A pixel outside the object takes a value from its nearest object pixels. If it lies between two object pixels, it takes their truncated average. If it has an object pixel on one side only, it copies that pixel. A companion mask output marks every pixel that now holds a defined value. A controller uses the mask as the updated shape map when it pads the columns in a second pass.

The line is a chain of identical elements joined by links in both directions. Each link is one pixel wide plus a validity flag. An element whose shape bit is set launches its own pixel both ways. An element whose shape bit is clear forwards whatever crosses it. So every element sees its nearest valid neighbour on each side within one combinational pass. A mode input splits the chain into two independent halves. With the defaults, that gives one 16-pixel luminance line or two 8-pixel chrominance lines. The result is registered, giving one clock of latency.

Top module: `pad_line_unit`

## Requirements
- R1: A lane whose shape bit is 1 outputs its own input pixel unchanged, with mask 1.
- R2: A lane with shape bit 0 whose nearest valid lanes on both sides are its direct neighbours outputs floor((left + right) / 2). The sum is formed one bit wider than a pixel, so 255 and 255 give 255 and 255 and 253 give 254.
- R3: A lane with shape bit 0 that has a valid lane on only one side, within its segment, outputs that nearest valid pixel unchanged. The segment ends act as invalid zero inputs.
- R4: A lane with shape bit 0 whose nearest valid lanes are several positions away on both sides outputs the floor average of those two nearest valid pixels. Farther valid pixels have no effect.
- R5: When a segment contains no lane with shape bit 1, every lane of that segment outputs pixel 0 with mask 0.
- R6: Every lane of a segment that contains at least one shape-1 lane outputs mask 1.
- R7: With split_mode 0 the sixteen lanes form one line. With split_mode 1, lanes 0-7 and lanes 8-15 are padded as two separate lines, and no value crosses between lane 7 and lane 8.
- R8: Outputs are registered. pix_out and mask_out reflect the inputs present at the preceding rising clock edge, and an active-low reset clears both to 0.
- R9: Lane i occupies bits [i*8 +: 8] of pix_in and pix_out and bit i of shape_in and mask_out. Lane 0 is the left end of the line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| split_mode | input | 1 | 0: one 16-lane line, 1: two 8-lane lines |
| pix_in | input | 128 | Input pixels, lane i in bits [i*8 +: 8] |
| shape_in | input | 16 | Object membership, one bit per lane |
| pix_out | output | 128 | Padded pixels, registered |
| mask_out | output | 16 | Lanes holding a defined value, registered |

## Verification
Replication at a line end and averaging in the interior of the same line are resolved in the same cycle by one chain. In split mode, the two halves are also padded in the same cycle, so one half can replicate toward lane 7 while the other averages or replicates away from lane 8. The bench provokes both conditions by sweeping every one of the 65536 shape patterns in each mode, with pixel values that change from vector to vector. It judges every lane against a nearest-valid search restricted to that lane's segment, which it runs itself. Directed vectors at full-scale values confirm the widened sum.

// File: rtl/pad_pkg.sv
`timescale 1ns/1ps
package pad_pkg;
  typedef enum logic {
    LINE_WHOLE = 1'b0,
    LINE_SPLIT = 1'b1
  } line_mode_e;

  // floor average of two 8-bit values using a 9-bit sum
  function automatic logic [7:0] half_sum8(input logic [7:0] a, input logic [7:0] b);
    logic [8:0] s;
    s = {1'b0, a} + {1'b0, b};
    return s[8:1];
  endfunction
endpackage

// File: rtl/pad_elem.sv
`timescale 1ns/1ps
module pad_elem #(
  parameter int W = 8
) (
  input  logic [W:0]   from_left,
  input  logic [W:0]   from_right,
  input  logic [W-1:0] pix,
  input  logic         shp,
  output logic [W:0]   to_left,
  output logic [W:0]   to_right,
  output logic [W-1:0] pout,
  output logic         defined
);
  logic         lval, rval;
  logic [W-1:0] lpix, rpix, opa, opb;
  logic [W:0]   sum;
  logic [W:0]   own;

  assign lval = from_left[W];
  assign rval = from_right[W];
  assign lpix = from_left[W-1:0];
  assign rpix = from_right[W-1:0];
  assign own  = {1'b1, pix};

  // a valid pixel launches itself both ways; otherwise links cross over
  assign to_right = shp ? own : from_left;
  assign to_left  = shp ? own : from_right;

  // a missing side borrows the other side, so one valid side replicates
  assign opa = lval ? lpix : (rval ? rpix : '0);
  assign opb = rval ? rpix : (lval ? lpix : '0);
  assign sum = {1'b0, opa} + {1'b0, opb};

  always_comb begin
    if (shp) pout = pix;
    else     pout = sum[W:1];
  end

  assign defined = shp | lval | rval;
endmodule

// File: rtl/pad_chain.sv
`timescale 1ns/1ps
module pad_chain #(
  parameter int W     = 8,
  parameter int LANES = 16
) (
  input  logic               split,
  input  logic [LANES*W-1:0] pix_flat,
  input  logic [LANES-1:0]   shp,
  output logic [LANES*W-1:0] pout_flat,
  output logic [LANES-1:0]   defined
);
  localparam int SEG = LANES / 2;

  logic [W:0] rlink [LANES];
  logic [W:0] llink [LANES];
  logic [W:0] lin   [LANES];
  logic [W:0] rin   [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    if (i == 0) begin : g_lend
      assign lin[i] = '0;
    end else if (i == SEG) begin : g_lsplit
      assign lin[i] = split ? '0 : rlink[i-1];
    end else begin : g_lmid
      assign lin[i] = rlink[i-1];
    end

    if (i == LANES - 1) begin : g_rend
      assign rin[i] = '0;
    end else if (i == SEG - 1) begin : g_rsplit
      assign rin[i] = split ? '0 : llink[i+1];
    end else begin : g_rmid
      assign rin[i] = llink[i+1];
    end

    pad_elem #(.W(W)) u_elem (
      .from_left (lin[i]),
      .from_right(rin[i]),
      .pix       (pix_flat[i*W +: W]),
      .shp       (shp[i]),
      .to_left   (llink[i]),
      .to_right  (rlink[i]),
      .pout      (pout_flat[i*W +: W]),
      .defined   (defined[i])
    );
  end
endmodule

// File: rtl/pad_line_unit.sv
`timescale 1ns/1ps
module pad_line_unit #(
  parameter int W     = 8,
  parameter int LANES = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               split_mode,
  input  logic [LANES*W-1:0] pix_in,
  input  logic [LANES-1:0]   shape_in,
  output logic [LANES*W-1:0] pix_out,
  output logic [LANES-1:0]   mask_out
);
  import pad_pkg::*;
  localparam int SEG = LANES / 2;

  line_mode_e         mode;
  logic [LANES*W-1:0] comb_pix;
  logic [LANES-1:0]   comb_mask;
  logic               primed;

  assign mode = line_mode_e'(split_mode);

  pad_chain #(.W(W), .LANES(LANES)) u_chain (
    .split    (mode == LINE_SPLIT),
    .pix_flat (pix_in),
    .shp      (shape_in),
    .pout_flat(comb_pix),
    .defined  (comb_mask)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pix_out  <= '0;
      mask_out <= '0;
      primed   <= 1'b0;
    end else begin
      pix_out  <= comb_pix;
      mask_out <= comb_mask;
      primed   <= 1'b1;
    end
  end

  // ---- assertions ----
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    p_keep_r1: assert property (@(posedge clk) disable iff (!rst_n)
      primed && $past(shape_in[i]) |->
        pix_out[i*W +: W] == $past(pix_in[i*W +: W]) && mask_out[i]);

    if (i > 0 && i < LANES - 1 && i != SEG - 1 && i != SEG) begin : g_avg
      p_avg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        primed && $past(!shape_in[i] && shape_in[i-1] && shape_in[i+1]) |->
          pix_out[i*W +: W] ==
            ({1'b0, $past(pix_in[(i-1)*W +: W])} + {1'b0, $past(pix_in[(i+1)*W +: W])}) >> 1);
    end
  end

  p_left_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(!shape_in[0] && shape_in[1]) |->
      pix_out[W-1:0] == $past(pix_in[2*W-1:W]) && mask_out[0]);

  p_empty_r5: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(shape_in == '0) |-> pix_out == '0 && mask_out == '0);

  p_isolate_r7: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $past(split_mode && shape_in[SEG-1:0] == '0) |->
      mask_out[SEG-1:0] == '0 && pix_out[SEG*W-1:0] == '0);

  p_reset_r8: assert property (@(posedge clk) !rst_n |-> mask_out == '0 && pix_out == '0);
endmodule

// File: tb/pad_line_unit_bench.sv
`timescale 1ns/1ps
module pad_line_unit_bench;
  localparam int W = 8;
  localparam int L = 16;
  localparam int SEG = L / 2;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           split_mode = 1'b0;
  logic [L*W-1:0] pix_in = '0;
  logic [L-1:0]   shape_in = '0;
  logic [L*W-1:0] pix_out;
  logic [L-1:0]   mask_out;

  int  checks = 0;
  int  fails = 0;
  bit  done = 1'b0;
  logic [W-1:0] px [L];

  always #5 clk = ~clk;

  pad_line_unit #(.W(W), .LANES(L)) u_pad_line_unit (
    .clk(clk), .rst_n(rst_n), .split_mode(split_mode),
    .pix_in(pix_in), .shape_in(shape_in),
    .pix_out(pix_out), .mask_out(mask_out)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // R9 lane packing
  task automatic drive(input logic [L-1:0] s, input logic sp);
    @(negedge clk);
    for (int i = 0; i < L; i++) pix_in[i*W +: W] = px[i];
    shape_in   = s;
    split_mode = sp;
  endtask

  // independent model: nearest valid search inside the lane's segment
  task automatic judge(input logic [L-1:0] s, input logic sp);
    for (int i = 0; i < L; i++) begin
      int lo, hi, lf, rf, ev, em;
      string tag;
      lo = (sp && i >= SEG) ? SEG : 0;
      hi = (sp && i < SEG) ? SEG - 1 : L - 1;
      lf = -1; rf = -1;
      for (int j = i - 1; j >= lo; j--) if (s[j] && lf < 0) lf = j;
      for (int j = i + 1; j <= hi; j++) if (s[j] && rf < 0) rf = j;
      if (s[i]) begin
        ev = px[i]; em = 1; tag = "R1";
      end else if (lf >= 0 && rf >= 0) begin
        ev = (int'(px[lf]) + int'(px[rf])) / 2; em = 1;
        tag = (lf == i - 1 && rf == i + 1) ? "R2" : "R4";
      end else if (lf >= 0) begin
        ev = px[lf]; em = 1; tag = "R3";
      end else if (rf >= 0) begin
        ev = px[rf]; em = 1; tag = "R3";
      end else begin
        ev = 0; em = 0; tag = "R5";
      end
      if (sp) tag = {"R7/", tag};
      chk(int'(pix_out[i*W +: W]) == ev, tag, int'(pix_out[i*W +: W]), ev);
      chk(int'(mask_out[i]) == em, sp ? "R7/R6 mask" : "R6 mask", int'(mask_out[i]), em);
    end
  endtask

  task automatic run(input logic [L-1:0] s, input logic sp);
    drive(s, sp);
    @(posedge clk);
    #1;
    judge(s, sp);
  endtask

  task automatic fill_px(input int seed);
    for (int i = 0; i < L; i++)
      px[i] = W'((seed * 131 + i * 57 + (seed >> 4) * (i + 3) + (seed >> 9)) & 255);
  endtask

  initial begin
    // R8 reset state
    for (int i = 0; i < L; i++) px[i] = 8'hA5;
    drive(16'hFFFF, 1'b0);
    @(posedge clk); #1;
    chk(pix_out == '0, "R8 reset pix", int'(pix_out[7:0]), 0);
    chk(mask_out == '0, "R8 reset mask", int'(mask_out), 0);
    rst_n = 1'b1;

    // R8 latency: output holds previous result until the edge
    for (int i = 0; i < L; i++) px[i] = W'(i * 10 + 1);
    run(16'h0001, 1'b0);
    drive(16'h8000, 1'b0);
    #1;
    chk(int'(pix_out[W-1:0]) == 1, "R8 latency hold", int'(pix_out[W-1:0]), 1);
    @(posedge clk); #1;
    chk(int'(pix_out[W-1:0]) == 151, "R8 latency update", int'(pix_out[W-1:0]), 151);

    // R2 wide sum at full scale
    for (int i = 0; i < L; i++) px[i] = 8'd255;
    run(16'h5555, 1'b0);
    for (int i = 0; i < L; i++) px[i] = (i % 4 == 0) ? 8'd255 : 8'd253;
    run(16'h5555, 1'b0);
    chk(int'(pix_out[W +: W]) == 254, "R2 overflow", int'(pix_out[W +: W]), 254);

    // R7 directed: value must not cross the split
    for (int i = 0; i < L; i++) px[i] = W'(200 - i);
    run(16'h0080, 1'b1);
    chk(int'(mask_out[SEG]) == 0, "R7 no crossing", int'(mask_out[SEG]), 0);
    run(16'h0080, 1'b0);
    chk(int'(pix_out[SEG*W +: W]) == 193, "R7 whole line reach", int'(pix_out[SEG*W +: W]), 193);

    // exhaustive shape sweeps in both modes
    for (int v = 0; v < 65536; v++) begin
      fill_px(v);
      run(L'(v), 1'b0);
    end
    for (int v = 0; v < 65536; v++) begin
      fill_px(v + 7777);
      run(L'(v), 1'b1);
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_900_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule